// File: doc/BRIEF.md
# Binary Window Majority Filter

This block cleans up a one-bit image mask, such as a skin-colour segmentation map, by deciding every pixel from its 7x7 neighbourhood. Each accepted beat carries all 49 bits of one window. The block counts the set bits in a short pipelined adder tree. The output pixel is 1 only when the count is strictly greater than a threshold, 37 by default, which is about three quarters of the neighbourhood. Isolated specks of noise are therefore wiped out, and the edges of mask regions shrink, much as with an erosion.

At the start of a frame the window generator upstream produces partial windows while its line stores fill. The block counts the beats it accepts after reset and after every frame-start pulse. The first 48 of these beats, set by a parameter, are consumed and produce no output. Only later beats reach the output.

Both data edges use a valid/ready handshake. A beat moves on any rising edge where its valid and ready are both high. The output side may apply back-pressure: while `res_valid` is high and `res_ready` is low, the result is held unchanged and `win_ready` drops, so the whole pipeline freezes. Once a beat is offered on `win_valid` it stays offered until it is accepted.

Top module: `bin_win_major`

## Requirements
- R1: After a synchronous reset, `res_valid` and `res_pix` are 0 and `win_ready` is 1, and any results that were in flight are discarded.
- R2: For a beat that passes the start-up gate, `res_pix` is 1 when the number of ones in `win_bits` is greater than 37 and is 0 otherwise. A count of 37 gives 0 and a count of 38 gives 1.
- R3: The result depends only on how many bits of the window are set, not on their positions. Bit `r*7+c` holds row r, column c.
- R4: After reset, the first 48 accepted beats produce no result. The 49th accepted beat and every later one each produce exactly one result.
- R5: A high `frame_open` on a rising edge restarts the start-up count. A beat accepted on that same edge counts as the first beat of the new frame.
- R6: When `res_ready` is held high, a result is visible three rising edges after its acceptance edge, counting the acceptance edge itself. One result can leave on every cycle.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid` and `res_pix` hold their values on the next edge and `win_ready` is 0.
- R8: `res_pix` is 0 whenever `res_valid` is 0.
- R9: Results leave in the order their beats were accepted, with none lost or duplicated under any pattern of back-pressure.
- R10: An edge where `win_valid` is 0 neither advances the start-up count nor produces a result, whatever `win_bits` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_open | input | 1 | Frame-start pulse that restarts the start-up count |
| win_valid | input | 1 | A window beat is offered |
| win_ready | output | 1 | The block can take a beat on this edge |
| win_bits | input | 49 | Window bits, row r column c at bit r*7+c |
| res_valid | output | 1 | A filtered pixel is offered |
| res_ready | input | 1 | The consumer takes the pixel on this edge |
| res_pix | output | 1 | Filtered pixel, 1 when the count exceeds the threshold |

## Verification
The bench builds the block with its default parameters: a 7x7 window, a threshold of 37 and a start-up gap of 48 beats. With these values the exact decision boundary, counts of 37 and 38, can be driven directly, along with the extremes of 0 and 49 set bits and the full 48-beat start-up gap, both after reset and after a frame-start pulse that arrives mid-stream. Windows of the same count but with different bit layouts test that position has no effect. A phase with random back-pressure tests the stall, ordering and hold rules.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  // bits needed to hold any value from 0 to n inclusive
  function automatic int cnt_width(int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/bwm_row_pop.sv
// Combinational count of the set bits of one window row.
module bwm_row_pop #(
  parameter int COLS = 7,
  localparam int CW = bwm_pkg::cnt_width(COLS)
) (
  input  logic [COLS-1:0] bits,
  output logic [CW-1:0]   ones
);

  always_comb begin
    ones = '0;
    for (int i = 0; i < COLS; i++) begin
      ones = ones + CW'(bits[i]);
    end
  end

endmodule

// File: rtl/bwm_gate.sv
// Start-up gate: counts accepted beats since reset or frame start and
// qualifies a beat only once SKIP beats have gone before it.
module bwm_gate #(
  parameter int SKIP = 48,
  localparam int GW = bwm_pkg::cnt_width(SKIP)
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_open,
  input  logic accept,
  output logic qual
);

  localparam logic [GW-1:0] SKIP_V = GW'(SKIP);

  logic [GW-1:0] seen_q;

  // the beat on a frame-start edge is beat zero of the new frame
  always_comb begin
    if (frame_open) qual = (SKIP == 0);
    else            qual = (seen_q >= SKIP_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
    end else if (frame_open) begin
      seen_q <= GW'(accept);
    end else if (accept && (seen_q < SKIP_V)) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  AST_GATE_SATURATES: assert property (@(posedge clk) disable iff (rst)
    seen_q <= SKIP_V); // R4

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
    frame_open |=> (seen_q <= GW'(1))); // R5

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!accept && !frame_open) |=> $stable(seen_q)); // R10

endmodule

// File: rtl/bwm_tree.sv
// Two-stage adder tree: stage A holds per-row counts, stage B the total.
// Only beats that are accepted and qualified travel as "keep".
module bwm_tree #(
  parameter int ROWS = 7,
  parameter int COLS = 7,
  localparam int NBITS = ROWS * COLS,
  localparam int RW = bwm_pkg::cnt_width(COLS),
  localparam int SW = bwm_pkg::cnt_width(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             in_keep,
  input  logic [NBITS-1:0] in_bits,
  output logic             sum_keep,
  output logic [SW-1:0]    sum_val
);

  logic [RW-1:0] row_ones [ROWS];
  logic [RW-1:0] a_row    [ROWS];
  logic          a_keep;
  logic [SW-1:0] a_total;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    bwm_row_pop #(.COLS(COLS)) u_pop (
      .bits (in_bits[r*COLS +: COLS]),
      .ones (row_ones[r])
    );

    always_ff @(posedge clk) begin
      if (rst)      a_row[r] <= '0;
      else if (adv) a_row[r] <= row_ones[r];
    end
  end

  always_comb begin
    a_total = '0;
    for (int r = 0; r < ROWS; r++) begin
      a_total = a_total + SW'(a_row[r]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_keep   <= 1'b0;
      sum_keep <= 1'b0;
      sum_val  <= '0;
    end else if (adv) begin
      a_keep   <= in_keep;
      sum_keep <= a_keep;
      sum_val  <= a_total;
    end
  end

  AST_SUM_RANGE: assert property (@(posedge clk) disable iff (rst)
    sum_val <= SW'(NBITS)); // R2

  AST_TREE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(sum_val) && $stable(sum_keep) && $stable(a_keep))); // R7

endmodule

// File: rtl/bin_win_major.sv
// Top: binary window majority filter with start-up gate and
// valid/ready handshakes on both data edges.
module bin_win_major #(
  parameter int ROWS   = 7,
  parameter int COLS   = 7,
  parameter int THRESH = 37,
  parameter int SKIP   = ROWS * COLS - 1,
  localparam int NBITS = ROWS * COLS,
  localparam int SW = bwm_pkg::cnt_width(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_open,
  input  logic             win_valid,
  output logic             win_ready,
  input  logic [NBITS-1:0] win_bits,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_pix
);

  localparam logic [SW-1:0] THR_V = SW'(THRESH);

  logic          adv;
  logic          accept;
  logic          qual;
  logic          b_keep;
  logic [SW-1:0] b_sum;

  // the pipeline moves only when the output register can be refilled
  assign adv       = !res_valid || res_ready;
  assign win_ready = adv;
  assign accept    = win_valid && adv;

  bwm_gate #(.SKIP(SKIP)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .frame_open (frame_open),
    .accept     (accept),
    .qual       (qual)
  );

  bwm_tree #(.ROWS(ROWS), .COLS(COLS)) u_tree (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .in_keep  (accept && qual),
    .in_bits  (win_bits),
    .sum_keep (b_keep),
    .sum_val  (b_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_pix   <= 1'b0;
    end else if (adv) begin
      res_valid <= b_keep;
      res_pix   <= b_keep && (b_sum > THR_V);
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pix))); // R7

  AST_PIX_QUIET: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !res_pix); // R8

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |-> !u_gate.accept); // R7

endmodule

// File: tb/bin_win_major_test.sv
`timescale 1ns/100ps
module bin_win_major_test;

  localparam int NB   = 49;
  localparam int THR  = 37;
  localparam int GAP  = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_open = 1'b0;
  logic          win_valid = 1'b0;
  logic          win_ready;
  logic [NB-1:0] win_bits = '0;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic          res_pix;

  always #2.5 clk = ~clk;

  bin_win_major uut (
    .clk        (clk),
    .rst        (rst),
    .frame_open (frame_open),
    .win_valid  (win_valid),
    .win_ready  (win_ready),
    .win_bits   (win_bits),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_pix    (res_pix)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int nout = 0;
  int gcnt = 0;
  bit stall_mode = 1'b0;
  bit prev_stall = 1'b0;
  bit prev_pix = 1'b0;
  bit done = 1'b0;
  int exp_val[$];
  int exp_cyc[$];
  bit exp_ff[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // window with exactly n ones, scattered by stride s and offset o
  function automatic logic [NB-1:0] mk_win(int n, int s, int o);
    logic [NB-1:0] w = '0;
    for (int i = 0; i < n; i++) w[(i * s + o) % NB] = 1'b1;
    return w;
  endfunction

  // reference model and per-cycle comparison, sampled mid-cycle
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      exp_val.delete(); exp_cyc.delete(); exp_ff.delete();
      gcnt = 0;
      prev_stall = 1'b0;
    end else begin
      if (prev_stall) begin
        chk(res_valid == 1'b1, "R7 hold valid", res_valid, 1);
        chk(res_pix == prev_pix, "R7 hold pix", res_pix, prev_pix);
      end
      if (!res_valid) chk(res_pix == 1'b0, "R8 quiet pix", res_pix, 0);
      if (res_valid && !res_ready) chk(win_ready == 1'b0, "R7 ready low", win_ready, 0);
      if (res_valid) begin
        chk(exp_val.size() > 0, "R9 unexpected result", exp_val.size(), 1);
        if (res_ready && exp_val.size() > 0) begin
          chk(res_pix == exp_val[0][0], "R2 pixel value", res_pix, exp_val[0]);
          if (exp_ff[0]) chk(cyc - exp_cyc[0] == 3, "R6 latency", cyc - exp_cyc[0], 3);
          void'(exp_val.pop_front()); void'(exp_cyc.pop_front()); void'(exp_ff.pop_front());
          nout++;
        end
      end
      prev_stall = res_valid && !res_ready;
      prev_pix = res_pix;
      if (frame_open) gcnt = 0;
      if (win_valid && win_ready) begin
        if (gcnt >= GAP) begin
          exp_val.push_back(($countones(win_bits) > THR) ? 1 : 0);
          exp_cyc.push_back(cyc);
          exp_ff.push_back(!stall_mode);
        end
        if (gcnt < GAP) gcnt++;
      end
    end
  end

  // random back-pressure when enabled
  always @(posedge clk) begin
    #1;
    if (stall_mode) res_ready <= ($urandom % 3) != 0;
    else            res_ready <= 1'b1;
  end

  task automatic beat(input logic [NB-1:0] w, input bit fs);
    win_valid = 1'b1; win_bits = w; frame_open = fs;
    @(negedge clk);
    while (!win_ready) @(negedge clk);
    @(posedge clk); #1;
    frame_open = 1'b0;
  endtask

  task automatic idle(input int n);
    win_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      win_bits = mk_win(NB, 1, 0) ^ NB'(i);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    int base;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 0, "R1 reset valid", res_valid, 0);
    chk(res_pix == 0, "R1 reset pix", res_pix, 0);
    chk(win_ready == 1, "R1 reset ready", win_ready, 1);
    @(posedge clk); #1;

    // R4: 48 full windows are swallowed
    for (int i = 0; i < GAP; i++) beat(mk_win(NB, 1, 0), 1'b0);
    idle(5);
    chk(nout == 0, "R4 start-up gap", nout, 0);
    // boundary and layout cases, back to back (R2, R3, R6)
    beat(mk_win(38, 10, 0), 1'b0);
    beat(mk_win(37, 10, 0), 1'b0);
    beat(mk_win(38, 3, 7), 1'b0);
    beat(mk_win(37, 20, 11), 1'b0);
    beat(mk_win(0, 1, 0), 1'b0);
    beat(mk_win(49, 1, 0), 1'b0);
    beat(mk_win(45, 5, 2), 1'b0);
    beat(mk_win(12, 8, 4), 1'b0);
    idle(5);
    chk(nout == 8, "R4 R6 results after gap", nout, 8);
    // R10: idle cycles with changing data do nothing
    idle(20);
    chk(nout == 8, "R10 idle produces nothing", nout, 8);

    // R5: frame start mid-stream, its own beat is beat zero
    base = nout;
    beat(mk_win(49, 1, 0), 1'b1);
    for (int i = 1; i < GAP; i++) beat(mk_win(49, 1, 0), 1'b0);
    idle(5);
    chk(nout == base, "R5 restart gap", nout, base);
    beat(mk_win(40, 4, 1), 1'b0);
    idle(5);
    chk(nout == base + 1, "R5 first result of frame", nout, base + 1);

    // R7, R9: random back-pressure
    stall_mode = 1'b1;
    base = nout;
    for (int i = 0; i < 80; i++) beat(mk_win((i * 7) % 50, 1 + 2 * (i % 3), i), 1'b0);
    win_valid = 1'b0;
    stall_mode = 1'b0;
    idle(10);
    chk(nout == base + 80, "R9 none lost", nout, base + 80);
    chk(exp_val.size() == 0, "R9 queue drained", exp_val.size(), 0);

    // R1: reset with results in flight
    beat(mk_win(49, 1, 0), 1'b0);
    beat(mk_win(49, 1, 0), 1'b0);
    win_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 0, "R1 flush valid", res_valid, 0);
    idle(6);
    chk(res_valid == 0, "R1 nothing after flush", res_valid, 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual running expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule